// File: doc/BRIEF.md
# Thinning Convergence Monitor

This block decides when an iterative two-pass skeletonisation of a binary image has stopped making progress. It watches the per-pixel result stream of the thinning engine. During the first subiteration pass of each iteration, it counts every valid pixel reported as deleted or background. At the frame end that closes that pass, the count is captured and compared with the capture from the previous iteration. The second subiteration pass does not change the captured value, and its frame end clears the counter for the next iteration.

Two equal captures in a row mean that no pixel was removed during a whole iteration, so the monitor raises a sticky done flag. The absolute difference between consecutive captures is reported as the progress made in that iteration. An optional iteration limit forces completion and raises a timeout flag when the image has not converged by then. A start pulse re-arms the monitor for a new image.

Top module: `thin_conv_mon`

## Requirements
- R1: After reset, and in the cycle after a start pulse, done_o, timeout_o, count_o and delta_o are all zero.
- R2: While subit_i is 0, the counter advances by one in each cycle where pix_vld_i and pix_del_i are both 1. A cycle with pix_vld_i at 0 is not counted.
- R3: Pixels presented while subit_i is 1 are never counted, and the frame end of that pass leaves count_o and delta_o unchanged.
- R4: A frame_end_i pulse with subit_i at 0 loads count_o in the next cycle. The loaded value includes a deleted pixel presented in the same cycle as the pulse.
- R5: A frame_end_i pulse with subit_i at 1 clears the counter, so each iteration's capture counts only the pixels of its own first pass.
- R6: The first capture after a start makes no comparison: delta_o is 0 and done_o stays 0, even when that capture is zero.
- R7: On every later capture, delta_o is the absolute difference between the new capture and the previous one.
- R8: A capture equal to the previous capture sets done_o to 1 and leaves timeout_o at 0. This holds even when the iteration limit is reached by the same capture.
- R9: Once done_o is 1, it stays 1, and count_o and delta_o hold, whatever the stream does, until the next start pulse.
- R10: The counter saturates at 2^CNT_W-1 and does not wrap.
- R11: With max_iter_i nonzero, the max_iter_i-th capture after a start sets done_o and timeout_o if that capture did not converge. A max_iter_i of 0 disables the limit.
- R12: start_i takes priority over the pixel and frame-end inputs in the same cycle, and clears the counter, the capture history and the iteration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Re-arms the monitor for a new image |
| max_iter_i | input | ITER_W | Iteration limit; 0 disables the limit |
| pix_vld_i | input | 1 | Pixel result valid strobe |
| pix_del_i | input | 1 | Pixel is deleted or background |
| frame_end_i | input | 1 | End of a subiteration pass |
| subit_i | input | 1 | Pass identifier: 0 first subiteration, 1 second |
| done_o | output | 1 | Thinning finished (sticky) |
| timeout_o | output | 1 | Finished because the iteration limit was reached |
| count_o | output | CNT_W | Latest captured count |
| delta_o | output | CNT_W | Absolute change between the last two captures |

## Verification
Some properties are checked by assertions on every cycle. These are: the counter stays put at saturation; it stays put when neither an increment nor a clear is requested; the capture and the iteration count move only on a capture or a start; done is sticky and freezes the reported values; a timeout always comes with done. The remaining behaviour can only be shown by the bench's scenarios. That covers the captured numbers themselves, the absolute deltas, convergence on the second zero capture but not the first, the tie between convergence and the iteration limit, start priority, and counting a pixel that arrives on the frame-end cycle. The bench sweeps pairs of per-iteration counts against an arithmetic model to cover these.

// File: rtl/thin_mon_pkg.sv
package thin_mon_pkg;
  typedef enum logic {
    SUB_FIRST  = 1'b0,
    SUB_SECOND = 1'b1
  } subit_e;

  function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/thin_sat_cnt.sv
module thin_sat_cnt #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  logic [W-1:0] cnt_q;

  // value including this cycle's pixel
  always_comb begin
    nxt_o = cnt_q;
    if (inc_i && cnt_q != MAX_V) nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_V && !clr_i) |=> cnt_q == MAX_V);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/thin_iter_limit.sv
module thin_iter_limit #(
  parameter int ITER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cap_i,
  input  logic [ITER_W-1:0] max_i,
  output logic              hit_o
);
  localparam int XW = ITER_W + 1;

  logic [ITER_W-1:0] iter_q;
  logic [XW-1:0]     iter_nxt;

  assign iter_nxt = {1'b0, iter_q} + XW'(1);
  // this capture is the max_i-th one
  assign hit_o = cap_i && (max_i != '0) && (iter_nxt == {1'b0, max_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      iter_q <= '0;
    else if (start_i) iter_q <= '0;
    else if (cap_i)   iter_q <= iter_nxt[ITER_W-1:0];
  end

  // R11
  iter_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !start_i) |=> $stable(iter_q));
endmodule

// File: rtl/thin_cap_cmp.sv
module thin_cap_cmp #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cap_i,
  input  logic [W-1:0] val_i,
  input  logic         limit_i,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] delta_o,
  output logic         done_o,
  output logic         timeout_o
);
  import thin_mon_pkg::*;

  logic [W-1:0] cap_q, delta_q;
  logic         prev_q, done_q, tmo_q;
  logic         same;
  logic [31:0]  diff;

  assign same = prev_q && (val_i == cap_q);
  assign diff = abs_diff(32'(val_i), 32'(cap_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0; delta_q <= '0; prev_q <= 1'b0; done_q <= 1'b0; tmo_q <= 1'b0;
    end else if (start_i) begin
      cap_q <= '0; delta_q <= '0; prev_q <= 1'b0; done_q <= 1'b0; tmo_q <= 1'b0;
    end else if (cap_i && !done_q) begin
      cap_q   <= val_i;
      prev_q  <= 1'b1;
      delta_q <= prev_q ? diff[W-1:0] : '0;
      if (same) begin
        done_q <= 1'b1;
      end else if (limit_i) begin
        done_q <= 1'b1;
        tmo_q  <= 1'b1;
      end
    end
  end

  assign cap_o     = cap_q;
  assign delta_o   = delta_q;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> done_q && $stable(cap_q) && $stable(delta_q));

  // R11
  timeout_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |-> done_q);

  // R4
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !start_i) |=> $stable(cap_q) && $stable(delta_q));

  // R6
  first_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !prev_q && !start_i && !limit_i) |=> !done_q);
endmodule

// File: rtl/thin_conv_mon.sv
module thin_conv_mon #(
  parameter int CNT_W  = 18,
  parameter int ITER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic              pix_vld_i,
  input  logic              pix_del_i,
  input  logic              frame_end_i,
  input  logic              subit_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  delta_o
);
  import thin_mon_pkg::*;

  logic             first_pass, cap, clr, inc, hit, done;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign first_pass = (subit_e'(subit_i) == SUB_FIRST);
  assign inc = !start_i && !done && first_pass && pix_vld_i && pix_del_i;
  assign cap = !start_i && !done && first_pass && frame_end_i;
  assign clr = start_i || (!done && !first_pass && frame_end_i);

  thin_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .inc_i(inc),
    .cnt_o(cnt), .nxt_o(cnt_nxt)
  );

  thin_iter_limit #(.ITER_W(ITER_W)) u_lim (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cap_i(cap),
    .max_i(max_iter_i), .hit_o(hit)
  );

  thin_cap_cmp #(.W(CNT_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cap_i(cap),
    .val_i(cnt_nxt), .limit_i(hit), .cap_o(count_o), .delta_o(delta_o),
    .done_o(done), .timeout_o(timeout_o)
  );

  assign done_o = done;

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt == '0);
endmodule

// File: tb/sim_thin_conv_mon.sv
module sim_thin_conv_mon;
  localparam int CW   = 5;
  localparam int IW   = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, vld = 1'b0, del = 1'b0, fe = 1'b0, sub = 1'b0;
  logic [IW-1:0] max_it = '0;
  logic done, tmo;
  logic [CW-1:0] cnt, dlt;

  int checks = 0, errors = 0;
  int m_cap, m_dlt, m_iter, m_max;
  bit m_pv, m_done, m_to;

  always #2.5 clk = ~clk;

  thin_conv_mon #(.CNT_W(CW), .ITER_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .max_iter_i(max_it),
    .pix_vld_i(vld), .pix_del_i(del), .frame_end_i(fe), .subit_i(sub),
    .done_o(done), .timeout_o(tmo), .count_o(cnt), .delta_o(dlt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " count"}, int'(cnt), m_cap);
    chk({req, " delta"}, int'(dlt), m_dlt);
    chk({req, " done"}, int'(done), int'(m_done));
    chk({req, " timeout"}, int'(tmo), int'(m_to));
  endtask

  task automatic cyc(input bit s, input bit v, input bit d, input bit f, input bit u);
    start = s; vld = v; del = d; fe = f; sub = u;
    @(negedge clk);
    start = 0; vld = 0; del = 0; fe = 0; sub = 0;
  endtask

  task automatic do_start(input int mx);
    max_it = IW'(mx);
    m_max = mx; m_cap = 0; m_dlt = 0; m_iter = 0; m_pv = 0; m_done = 0; m_to = 0;
    cyc(1, 0, 0, 0, 0);
    chk_all("R1 start");
  endtask

  // d deleted + k kept pixels in pass one, s2 deleted in pass two
  task automatic iter(input int d, input int k, input int s2, input bit fp, input string req);
    int cap;
    for (int i = 0; i < d; i++) begin
      cyc(0, 1, 1, 0, 0);
      if (i == 0) cyc(0, 0, 1, 0, 0); // R2 invalid cycle not counted
    end
    for (int i = 0; i < k; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, fp, fp, 1, 0);
    if (!m_done) begin
      cap = d + int'(fp);
      if (cap > MAXC) cap = MAXC;
      m_iter++;
      if (m_pv) begin
        m_dlt = (cap >= m_cap) ? cap - m_cap : m_cap - cap;
        if (cap == m_cap) m_done = 1;
      end else m_dlt = 0;
      if (!m_done && m_max != 0 && m_iter == m_max) begin m_done = 1; m_to = 1; end
      m_cap = cap; m_pv = 1;
    end
    chk_all({req, " R4 R7 R8"});
    for (int i = 0; i < s2; i++) cyc(0, 1, 1, 0, 1);
    cyc(0, 0, 0, 1, 1);
    chk_all("R3 R5 second pass");
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    m_cap = 0; m_dlt = 0; m_done = 0; m_to = 0;
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    do_start(0);
    iter(3, 2, 4, 0, "R2");
    iter(7, 0, 9, 1, "R7");
    iter(12, 3, 0, 0, "R7");
    iter(11, 1, 2, 1, "R8");       // 12 again -> done
    iter(20, 0, 5, 1, "R9");       // ignored while done
    cyc(0, 1, 1, 0, 0);
    chk_all("R9 hold");

    do_start(0);
    iter(0, 4, 3, 0, "R6");        // zero first capture: no done
    iter(0, 2, 6, 0, "R8 zero");

    do_start(0);
    iter(40, 0, 0, 0, "R10");
    iter(35, 0, 0, 0, "R10 sat eq");

    do_start(0);
    iter(10, 0, 0, 0, "R7");
    iter(4, 0, 0, 0, "R7 decrease");

    do_start(3);
    iter(1, 0, 0, 0, "R11");
    iter(2, 0, 0, 0, "R11");
    iter(3, 0, 0, 0, "R11 limit");
    iter(9, 0, 0, 0, "R11 hold");

    do_start(2);
    iter(5, 0, 0, 0, "R8");
    iter(5, 0, 0, 0, "R8 tie limit");

    // R12 start with frame end and pixel in the same cycle
    do_start(0);
    iter(6, 0, 0, 0, "R12 pre");
    cyc(0, 1, 1, 0, 0);
    cyc(1, 1, 1, 1, 0);
    m_cap = 0; m_dlt = 0; m_iter = 0; m_pv = 0; m_done = 0; m_to = 0;
    chk_all("R12 priority");
    iter(2, 0, 0, 0, "R12 after");

    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++) begin
        do_start(0);
        iter(a, b % 3, a % 4, bit'((a + b) % 2), "R7 sweep");
        iter(b, a % 2, b % 3, bit'(a % 2), "R8 sweep");
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule